// File: doc/BRIEF.md
# Configuration store with security lock

This block holds the programming image of a sum-of-products logic array: one connection word per product term plus a short configuration field per output macrocell, all kept in internal flip-flops. A host drives it over a one-cycle command interface carrying an operation code, a row address and a write word. It can wipe the whole image, add connections to one row, read one row back, or lock the image against inspection and change.

The lock is sticky. Once set, every read-back and every row write is refused with a one-cycle error pulse, and the stored image stays as it was. The only way out is a bulk wipe. The wipe runs for a fixed number of cycles with `busy` high, opens every connection, clears every macrocell field and releases the lock in the same cycle. Writing a row can only add connections; removing one takes a full wipe followed by reprogramming. A typical session is: wipe, write the wanted rows, read them back, then lock, either at once or at some later point.

Top module: `cfg_lock_store`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `locked` are 0, `rdata` is 0, and every row reads back as 0, meaning all connections are open.
- R2: Operation code 2'b00 (wipe) is accepted while `busy` is low. `busy` is then high for exactly ERASE_CYCLES cycles, starting in the cycle after acceptance. `done` pulses for one cycle as `busy` falls, and from then on every row reads 0.
- R3: While `busy` is high, every command is ignored: no `done`, no `err`, no change to `rdata` or `locked`, and a wipe issued then does not lengthen the busy period.
- R4: Operation code 2'b01 (row write) ORs `cmd_wdata` into the addressed row, so it can set bits but never clear them. `done` pulses in the cycle after acceptance.
- R5: Rows TERMS to TERMS+CELLS-1 are macrocell fields. They keep only the low CELL_BITS bits of a write, and their upper bits always read 0. Rows 0 to TERMS-1 are full LINES-bit connection words.
- R6: Operation code 2'b10 (read-back) loads the addressed row into `rdata` and pulses `done`, both in the cycle after acceptance. `rdata` keeps its value until the next read-back command.
- R7: Operation code 2'b11 (lock) sets `locked` and pulses `done` in the cycle after acceptance. It is accepted whether or not the block is already locked.
- R8: While `locked` is 1, a row write or read-back gives an `err` pulse in the cycle after acceptance and no `done`. The stored rows are unchanged, and a refused read-back sets `rdata` to 0.
- R9: `locked` returns to 0 only at the end of a wipe, in the same cycle as that wipe's `done` pulse.
- R10: A row write or read-back to an address of TERMS+CELLS or more is refused with an `err` pulse and no `done`, and a refused read-back sets `rdata` to 0. Wipe and lock ignore the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 00 wipe, 01 row write, 10 read-back, 11 lock |
| cmd_addr | input | AW (7) | Row index; terms first, then macrocell fields |
| cmd_wdata | input | LINES (36) | Bits to add to the row on a write |
| busy | output | 1 | Wipe in progress; commands are ignored |
| done | output | 1 | One-cycle pulse: a command completed |
| err | output | 1 | One-cycle pulse: a command was refused |
| locked | output | 1 | Lock state of the image |
| rdata | output | LINES (36) | Last read-back word |

## Verification
The assertions assume the command inputs hold known values whenever `rst_n` is high. They also assume those inputs are sampled only at rising edges, so `cmd_valid` held high for several cycles counts as several back-to-back commands. The stimulus meets both assumptions: it changes the command inputs only on falling edges and drops `cmd_valid` after each command unless a burst is intended. Commands are also issued on purpose while `busy` is high, so the properties that check the ignore rule and the exact wipe length get real traffic to check.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
    typedef enum logic [1:0] {
        OP_WIPE   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_READ   = 2'b10,
        OP_LOCK   = 2'b11
    } cfg_op_e;
endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
    import cfg_lock_pkg::*;
#(
    parameter int TERMS     = 74,
    parameter int CELLS     = 8,
    parameter int CELL_BITS = 4,
    parameter int LINES     = 36,
    parameter int AW        = 7
) (
    input  logic             valid,
    input  logic [1:0]       op,
    input  logic [AW-1:0]    addr,
    input  logic             busy,
    input  logic             locked,
    output logic             go_wipe,
    output logic             go_write,
    output logic             go_read,
    output logic             go_lock,
    output logic             deny_write,
    output logic             deny_read,
    output logic [LINES-1:0] keep_mask
);
    localparam int            ROWS      = TERMS + CELLS;
    localparam logic [AW:0]   ROWS_W    = (AW+1)'(ROWS);
    localparam logic [AW:0]   TERMS_W   = (AW+1)'(TERMS);
    localparam logic [LINES-1:0] CELL_MASK =
        {{(LINES-CELL_BITS){1'b0}}, {CELL_BITS{1'b1}}};

    logic take;
    logic in_range;
    logic is_cell;
    logic allowed;
    cfg_op_e opc;

    always_comb begin
        opc        = cfg_op_e'(op);
        take       = valid && !busy;
        in_range   = {1'b0, addr} < ROWS_W;
        is_cell    = {1'b0, addr} >= TERMS_W;
        allowed    = in_range && !locked;
        go_wipe    = take && (opc == OP_WIPE);
        go_lock    = take && (opc == OP_LOCK);
        go_write   = take && (opc == OP_WRITE) && allowed;
        go_read    = take && (opc == OP_READ)  && allowed;
        deny_write = take && (opc == OP_WRITE) && !allowed;
        deny_read  = take && (opc == OP_READ)  && !allowed;
        keep_mask  = is_cell ? CELL_MASK : '1;
    end
endmodule

// File: rtl/cfg_wipe_timer.sv
module cfg_wipe_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fin
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          busy_d, busy_q;

    always_comb begin
        cnt_d  = cnt_q;
        busy_d = busy_q;
        fin    = busy_q && (cnt_q == '0);
        if (start) begin
            busy_d = 1'b1;
            cnt_d  = CW'(CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_d = 1'b0;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            busy_q <= busy_d;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/cfg_cell_array.sv
module cfg_cell_array #(
    parameter int ROWS  = 82,
    parameter int WIDTH = 36,
    parameter int AW    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [AW-1:0]    row,
    input  logic [WIDTH-1:0] wr_bits,
    output logic [WIDTH-1:0] rd_bits
);
    logic [WIDTH-1:0] row_all [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [WIDTH-1:0] row_d, row_q;
        logic             hit;

        always_comb begin
            hit   = wr_en && (row == AW'(r));
            row_d = row_q;
            if (clr) begin
                row_d = '0;
            end else if (hit) begin
                row_d = row_q | wr_bits;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q <= '0;
            end else begin
                row_q <= row_d;
            end
        end

        assign row_all[r] = row_q;
    end

    always_comb begin
        rd_bits = '0;
        if (int'(row) < ROWS) begin
            rd_bits = row_all[row];
        end
    end
endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store #(
    parameter int TERMS        = 74,
    parameter int LINES        = 36,
    parameter int CELLS        = 8,
    parameter int CELL_BITS    = 4,
    parameter int ERASE_CYCLES = 20,
    localparam int ROWS        = TERMS + CELLS,
    localparam int AW          = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [LINES-1:0] cmd_wdata,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             locked,
    output logic [LINES-1:0] rdata
);
    typedef struct packed {
        logic             done;
        logic             err;
        logic             locked;
        logic [LINES-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic             go_wipe, go_write, go_read, go_lock;
    logic             deny_write, deny_read;
    logic [LINES-1:0] keep_mask;
    logic [LINES-1:0] rd_bits;
    logic             wipe_busy, wipe_fin;

    cfg_cmd_decode #(
        .TERMS(TERMS), .CELLS(CELLS), .CELL_BITS(CELL_BITS),
        .LINES(LINES), .AW(AW)
    ) u_dec (
        .valid      (cmd_valid),
        .op         (cmd_op),
        .addr       (cmd_addr),
        .busy       (wipe_busy),
        .locked     (st_q.locked),
        .go_wipe    (go_wipe),
        .go_write   (go_write),
        .go_read    (go_read),
        .go_lock    (go_lock),
        .deny_write (deny_write),
        .deny_read  (deny_read),
        .keep_mask  (keep_mask)
    );

    cfg_wipe_timer #(.CYCLES(ERASE_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go_wipe),
        .busy  (wipe_busy),
        .fin   (wipe_fin)
    );

    cfg_cell_array #(.ROWS(ROWS), .WIDTH(LINES), .AW(AW)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wipe_fin),
        .wr_en   (go_write),
        .row     (cmd_addr),
        .wr_bits (cmd_wdata & keep_mask),
        .rd_bits (rd_bits)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = wipe_fin || go_write || go_read || go_lock;
        st_d.err  = deny_write || deny_read;
        if (wipe_fin) begin
            st_d.locked = 1'b0;
        end else if (go_lock) begin
            st_d.locked = 1'b1;
        end
        if (go_read) begin
            st_d.rdata = rd_bits & keep_mask;
        end else if (deny_read) begin
            st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = wipe_busy;
    assign done   = st_q.done;
    assign err    = st_q.err;
    assign locked = st_q.locked;
    assign rdata  = st_q.rdata;
endmodule

// File: rtl/cfg_lock_store_chk.sv
module cfg_lock_store_chk
    import cfg_lock_pkg::*;
#(
    parameter int LINES        = 36,
    parameter int ERASE_CYCLES = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             locked,
    input logic [LINES-1:0] rdata
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= '0;
        end
    end

    p_erase_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy && cmd_op == OP_WIPE |=> busy);

    p_erase_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == 32'(ERASE_CYCLES) && done);

    p_quiet_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done && !err);

    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && !busy && cmd_op == OP_READ) |=> $stable(rdata));

    p_lock_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy && cmd_op == OP_LOCK |=> locked && done);

    p_deny_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy && locked && (cmd_op == OP_WRITE || cmd_op == OP_READ)
        |=> err && !done);

    p_zero_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy && locked && cmd_op == OP_READ |=> rdata == '0);

    p_unlock_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> done && $past(busy));

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
endmodule

bind cfg_lock_store cfg_lock_store_chk #(
    .LINES(LINES), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .done(done), .err(err), .locked(locked), .rdata(rdata)
);

// File: tb/cfg_lock_store_test.sv
`timescale 1ns/1ps
module cfg_lock_store_test;
    localparam int TERMS = 74, LINES = 36, CELLS = 8, CELL_BITS = 4, ERASE_CYCLES = 20;
    localparam int ROWS = TERMS + CELLS;
    localparam int AW = $clog2(ROWS);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'b00;
    logic [AW-1:0]    cmd_addr = '0;
    logic [LINES-1:0] cmd_wdata = '0;
    logic             busy, done, err, locked;
    logic [LINES-1:0] rdata;

    cfg_lock_store #(.TERMS(TERMS), .LINES(LINES), .CELLS(CELLS),
                     .CELL_BITS(CELL_BITS), .ERASE_CYCLES(ERASE_CYCLES)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .err(err), .locked(locked), .rdata(rdata));

    int    total = 0;
    int    bad = 0;
    string tag = "R1";

    logic [LINES-1:0] m_mem [ROWS];
    int               m_busy = 0;
    bit               m_locked = 0, m_done = 0, m_err = 0;
    logic [LINES-1:0] m_rdata = '0;

    function automatic logic [LINES-1:0] mask_of(int a);
        if (a >= TERMS) return LINES'((1 << CELL_BITS) - 1);
        return '1;
    endfunction

    task automatic model_edge();
        int a;
        a = int'(cmd_addr);
        m_done = 0;
        m_err  = 0;
        if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) begin
                for (int i = 0; i < ROWS; i++) m_mem[i] = '0;
                m_locked = 0;
                m_done   = 1;
            end
        end else if (cmd_valid) begin
            case (cmd_op)
                2'b00: m_busy = ERASE_CYCLES;
                2'b01: if (m_locked || a >= ROWS) m_err = 1;
                       else begin m_mem[a] = m_mem[a] | (cmd_wdata & mask_of(a)); m_done = 1; end
                2'b10: if (m_locked || a >= ROWS) begin m_err = 1; m_rdata = '0; end
                       else begin m_rdata = m_mem[a] & mask_of(a); m_done = 1; end
                default: begin m_locked = 1; m_done = 1; end
            endcase
        end
    endtask

    task automatic compare();
        total++;
        if (busy !== (m_busy > 0) || done !== m_done || err !== m_err ||
            locked !== m_locked || rdata !== m_rdata) begin
            bad++;
            $display("FAIL %s: busy/done/err/locked/rdata actual %b%b%b%b %h expected %b%b%b%b %h",
                     tag, busy, done, err, locked, rdata,
                     m_busy > 0, m_done, m_err, m_locked, m_rdata);
        end
    endtask

    task automatic expect_rd(logic [LINES-1:0] v);
        total++;
        if (rdata !== v) begin
            bad++;
            $display("FAIL %s: rdata actual %h expected %h", tag, rdata, v);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic issue(logic [1:0] op, int addr, logic [LINES-1:0] data);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = AW'(addr);
        cmd_wdata = data;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) step();
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < ROWS; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        compare();                                   // R1 reset state
        rst_n = 1'b1;
        idle(2);
        tag = "R1";
        issue(2'b10, 5, '0);        expect_rd('0);
        issue(2'b10, TERMS + 1, '0); expect_rd('0);

        tag = "R4";
        issue(2'b01, 3, 36'h0_F0F0_0001);
        issue(2'b10, 3, '0);        expect_rd(36'h0_F0F0_0001);
        issue(2'b01, 3, 36'h8_0000_0F00);
        issue(2'b10, 3, '0);        expect_rd(36'h8_F0F0_0F01);
        issue(2'b01, 3, '0);
        issue(2'b10, 3, '0);        expect_rd(36'h8_F0F0_0F01);
        issue(2'b01, 0, '1);
        issue(2'b01, TERMS - 1, 36'h5_5555_5555);
        issue(2'b10, TERMS - 1, '0); expect_rd(36'h5_5555_5555);

        tag = "R5";
        issue(2'b01, TERMS + 2, '1);
        issue(2'b10, TERMS + 2, '0); expect_rd(36'h0_0000_000F);
        issue(2'b01, TERMS + CELLS - 1, 36'hF_FFFF_FFF5);
        issue(2'b10, TERMS + CELLS - 1, '0); expect_rd(36'h0_0000_0005);

        tag = "R6";
        issue(2'b10, 0, '0);
        idle(3);                    expect_rd('1);
        issue(2'b01, 0, '0);        expect_rd('1);

        tag = "R10";
        issue(2'b01, ROWS, '1);
        issue(2'b10, (1 << AW) - 1, '0); expect_rd('0);
        issue(2'b10, 3, '0);
        issue(2'b10, ROWS, '0);      expect_rd('0);

        tag = "R7";
        issue(2'b11, 99, '0);
        idle(1);
        issue(2'b11, 0, '0);

        tag = "R8";
        issue(2'b10, 3, '0);         expect_rd('0);
        issue(2'b01, 4, '1);
        issue(2'b01, 4, '1);
        issue(2'b10, 4, '0);

        tag = "R2";
        issue(2'b00, 0, '0);
        tag = "R3";
        issue(2'b01, 7, '1);
        issue(2'b10, 3, '0);
        issue(2'b11, 0, '0);
        issue(2'b00, 0, '0);
        idle(ERASE_CYCLES - 6);
        tag = "R9";
        idle(4);
        tag = "R2";
        issue(2'b10, 3, '0);          expect_rd('0);
        issue(2'b10, 0, '0);          expect_rd('0);
        issue(2'b10, TERMS + 2, '0);  expect_rd('0);

        tag = "R4";
        issue(2'b01, 9, 36'h1);
        issue(2'b10, 9, '0);          expect_rd(36'h1);
        tag = "R2";
        issue(2'b00, 9, '0);
        idle(ERASE_CYCLES + 1);
        issue(2'b10, 9, '0);          expect_rd('0);

        tag = "R7";
        issue(2'b01, 11, 36'hA);
        issue(2'b11, 0, '0);
        tag = "R9";
        idle(5);
        issue(2'b00, 0, '0);
        idle(ERASE_CYCLES + 1);
        issue(2'b10, 11, '0);         expect_rd('0);
        idle(2);
        finish_run();
    end
endmodule